// File: doc/BRIEF.md
# SDRAM Burst Column and Data Path

This block is the data-side engine of an SDRAM controller. It works on one row that is already open. A read or write command arrives with a starting column, and the block then produces the column address for every beat of the burst. For writes it drives the write data and the byte mask onto the device. For reads it places the mask early enough to blank the right beat, captures the returned data once the CAS latency has passed, and presents that data with a valid flag. Bank activation, precharge timing and refresh belong to other parts of the controller.

The burst length and CAS latency come in on configuration inputs. The burst length is latched with each command. The CAS latency is used live and must only change while no read is in flight. A burst can be cut short in two ways: a new command replaces it at once, or, when the active burst runs in full-page mode, a stop strobe ends it. Back-to-back read commands give read data with no gap.

Top module: `sdram_burst_path`

## Requirements
- R1: In the cycle of a write command (`cmd_valid`=1, `cmd_write`=1), `dq_oe` is 1, `col_addr` equals `cmd_col` and `dq_out` equals `wr_data`.
- R2: `burst_len` is latched at the command. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats on consecutive cycles. Any other code selects full-page mode.
- R3: The beats use sequential order. Each beat adds one to the column within the block that is aligned to the burst length, and wraps back to the start of that block while the upper column bits stay fixed.
- R4: `cas_lat` 0 means latency 2 and 1 means latency 3. `dq_in` is sampled in the cycle that lies CL cycles after a read beat's column cycle. It appears on `rd_data` with `rd_valid`=1 in the next cycle.
- R5: A `beat_mask` given with a read beat appears on `dqm` CL-2 cycles later. That beat produces no `rd_valid`.
- R6: During a write beat, `dqm` equals that cycle's `beat_mask` (zero latency).
- R7: A command that arrives during a burst ends the remaining beats at once and starts its own burst in the same cycle. Beats that were already issued still return their read data, so back-to-back reads give a gapless stream.
- R8: In full-page mode the column keeps counting, wraps from the last column of the row to column 0, and continues until a stop or a new command arrives.
- R9: `burst_stop` during a full-page burst, with no command in that cycle, suppresses that cycle's beat and ends the burst. During a burst of fixed length, `burst_stop` has no effect.
- R10: Read beats never assert `dq_oe`. `dq_oe` is 0 in every cycle that carries no write beat, including the cycle after a write burst's last beat.
- R11: While `rst_n` is low, the block holds no burst: `dq_oe`, `rd_valid` and (with no command present) `dqm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Read or write command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W | Starting column |
| burst_len | input | 3 | Burst length code (0..3 = 1/2/4/8, else full page) |
| cas_lat | input | 1 | 0 = CL2, 1 = CL3 |
| wr_data | input | DATA_W | Write data for the current beat |
| beat_mask | input | 1 | Mask for the current beat |
| burst_stop | input | 1 | Stop strobe, honoured in full-page mode |
| dq_in | input | DATA_W | Data returned by the device |
| col_addr | output | COL_W | Column address of the current beat |
| dqm | output | 1 | Data mask to the device |
| dq_out | output | DATA_W | Write data to the device |
| dq_oe | output | 1 | Drive enable for the data bus |
| rd_valid | output | 1 | Captured read beat is valid |
| rd_data | output | DATA_W | Captured read data |

## Verification
The bench targets several corner cases. A burst that starts in the middle of an aligned block must wrap inside that block; a design that carried into the upper column bits would step into the next block. A full-page burst is started two columns before the end of the row, and a counter that saturated or overflowed into the wrong block would show up there. Read masks are checked under both latencies, so a DQM that copied the write timing would blank the wrong beat. Writes and fixed-length bursts are hit by interrupting commands and by stop strobes, which exposes a design that let a stop cut a fixed burst, or let stale beats continue after a new command.

// File: rtl/sdram_burst_path.sv
module sdram_burst_path #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [2:0]        burst_len,
  input  logic              cas_lat,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              beat_mask,
  input  logic              burst_stop,
  input  logic [DATA_W-1:0] dq_in,
  output logic [COL_W-1:0]  col_addr,
  output logic              dqm,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [COL_W-1:0] ROW_WRAP = '1;

  logic [COL_W-1:0] wrap_sel, wrap_r, cur_col, remain, base_col, base_wrap, next_col;
  logic             full_sel, full_r, busy_r, wr_r;
  logic             stop_now, beat, beat_wr, wr_beat, rd_beat;
  logic [2:0]       rd_pipe;
  logic             rd_tap, mask_d1;

  always_comb begin
    full_sel = 1'b0;
    case (burst_len)
      3'd0:    wrap_sel = '0;
      3'd1:    wrap_sel = COL_W'(1);
      3'd2:    wrap_sel = COL_W'(3);
      3'd3:    wrap_sel = COL_W'(7);
      default: begin wrap_sel = ROW_WRAP; full_sel = 1'b1; end
    endcase
  end

  assign stop_now  = busy_r & full_r & burst_stop & ~cmd_valid;
  assign beat      = cmd_valid | (busy_r & ~stop_now);
  assign beat_wr   = cmd_valid ? cmd_write : wr_r;
  assign wr_beat   = beat & beat_wr;
  assign rd_beat   = beat & ~beat_wr;
  assign base_col  = cmd_valid ? cmd_col : cur_col;
  assign base_wrap = cmd_valid ? wrap_sel : wrap_r;
  assign next_col  = (base_col & ~base_wrap) | ((base_col + 1'b1) & base_wrap);

  assign col_addr = base_col;
  assign dq_oe    = wr_beat;
  assign dq_out   = wr_data;
  assign dqm      = wr_beat ? beat_mask : (cas_lat ? mask_d1 : (rd_beat & beat_mask));
  assign rd_tap   = cas_lat ? rd_pipe[2] : rd_pipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_r  <= '0;
      cur_col <= '0;
      remain  <= '0;
      full_r  <= 1'b0;
      busy_r  <= 1'b0;
      wr_r    <= 1'b0;
    end else if (cmd_valid) begin
      wrap_r  <= wrap_sel;
      full_r  <= full_sel;
      wr_r    <= cmd_write;
      remain  <= wrap_sel;
      busy_r  <= full_sel | (wrap_sel != '0);
      cur_col <= next_col;
    end else if (busy_r) begin
      if (stop_now) begin
        busy_r <= 1'b0;
      end else begin
        cur_col <= next_col;
        if (!full_r) begin
          remain <= remain - 1'b1;
          busy_r <= (remain != COL_W'(1));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      mask_d1  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[1:0], rd_beat & ~beat_mask};
      mask_d1  <= rd_beat & beat_mask;
      rd_valid <= rd_tap;
      if (rd_tap) rd_data <= dq_in;
    end
  end

endmodule

module sdram_burst_path_chk #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [COL_W-1:0]  cmd_col,
  input logic [2:0]        burst_len,
  input logic              cas_lat,
  input logic              beat_mask,
  input logic [COL_W-1:0]  col_addr,
  input logic              dqm,
  input logic              dq_oe,
  input logic              rd_valid
);

  AST_WR_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |-> dq_oe && col_addr == cmd_col); // R1

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && burst_len == 3'd0 ##1 !cmd_valid |-> !dq_oe); // R2

  AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && burst_len == 3'd3 ##1 !cmd_valid |->
      dq_oe && col_addr[COL_W-1:3] == $past(cmd_col[COL_W-1:3]) &&
      col_addr[2:0] == $past(cmd_col[2:0]) + 3'd1); // R3

  AST_RD_DATA_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && !cas_lat && !beat_mask |-> ##3 rd_valid); // R4

  AST_RD_DATA_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && cas_lat && !beat_mask |-> ##4 rd_valid); // R4

  AST_RD_MASK_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && !cas_lat && beat_mask |-> dqm); // R5

  AST_RD_MASK_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && cas_lat && beat_mask |=> dqm || dq_oe); // R5

  AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqm == beat_mask); // R6

  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> !dq_oe); // R10

endmodule

bind sdram_burst_path sdram_burst_path_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_col(cmd_col), .burst_len(burst_len), .cas_lat(cas_lat), .beat_mask(beat_mask),
  .col_addr(col_addr), .dqm(dqm), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/sdram_burst_path_bench.sv
`timescale 1ns/1ps
module sdram_burst_path_bench;
  localparam int COL_W  = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_v = 0, c_w = 0, cl = 0, bm = 0, stp = 0;
  logic [COL_W-1:0]  c_col = '0;
  logic [2:0]        c_len = '0;
  logic [DATA_W-1:0] wd = '0, dqi = '0;
  logic [COL_W-1:0]  col_addr;
  logic              dqm, dq_oe, rd_valid;
  logic [DATA_W-1:0] dq_out, rd_data;

  always #2.5 clk = ~clk;

  sdram_burst_path #(.COL_W(COL_W), .DATA_W(DATA_W)) u_sdram_burst_path (
    .clk(clk), .rst_n(rst_n), .cmd_valid(c_v), .cmd_write(c_w), .cmd_col(c_col),
    .burst_len(c_len), .cas_lat(cl), .wr_data(wd), .beat_mask(bm), .burst_stop(stp),
    .dq_in(dqi), .col_addr(col_addr), .dqm(dqm), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_valid(rd_valid), .rd_data(rd_data));

  int n_chk = 0, n_bad = 0, k = 0;
  bit done = 0;
  string focus = "";

  bit m_busy = 0, m_full = 0, m_wr = 0, m_maskd = 0, mrv = 0;
  logic [COL_W-1:0] m_col = '0, m_wrap = '0;
  int m_left = 0;
  logic [DATA_W-1:0] mrd = '0;
  bit sched [16];

  function automatic logic [COL_W-1:0] wrap_of(logic [2:0] code);
    return (code > 3'd3) ? {COL_W{1'b1}} : COL_W'((1 << code) - 1);
  endfunction

  function automatic logic [COL_W-1:0] nxt(logic [COL_W-1:0] c, logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h",
               focus != "" ? focus : req, what, k, act, exp);
    end
  endtask

  task automatic step();
    bit beat, wr, rdb, wrb, e_dqm;
    logic [COL_W-1:0] col;
    dqi = DATA_W'($urandom);
    #1;
    beat = 0; wr = 0; col = '0;
    if (c_v) begin beat = 1; wr = c_w; col = c_col; end
    else if (m_busy && !(m_full && stp)) begin beat = 1; wr = m_wr; col = m_col; end
    rdb = beat && !wr;
    wrb = beat && wr;
    e_dqm = wrb ? bm : (cl ? m_maskd : (rdb && bm));
    chk(dq_oe == wrb, c_v ? "R1" : (beat ? "R2" : "R10"), "dq_oe", 32'(dq_oe), 32'(wrb));
    if (beat) chk(col_addr == col, c_v ? "R1" : (m_full ? "R8" : "R3"), "col_addr",
                  32'(col_addr), 32'(col));
    if (wrb) chk(dq_out == wd, "R1", "dq_out", 32'(dq_out), 32'(wd));
    chk(dqm == e_dqm, wrb ? "R6" : "R5", "dqm", 32'(dqm), 32'(e_dqm));
    chk(rd_valid == mrv, "R4", "rd_valid", 32'(rd_valid), 32'(mrv));
    if (mrv) chk(rd_data == mrd, "R4", "rd_data", 32'(rd_data), 32'(mrd));
    if (rdb && !bm) sched[(k + (cl ? 3 : 2)) % 16] = 1;
    @(posedge clk);
    if (c_v) begin
      m_wrap = wrap_of(c_len);
      m_full = (c_len > 3'd3);
      m_wr   = c_w;
      m_left = int'(m_wrap);
      m_busy = m_full || (m_left > 0);
      m_col  = nxt(c_col, m_wrap);
    end else if (m_busy) begin
      if (m_full && stp) m_busy = 0;
      else begin
        m_col = nxt(m_col, m_wrap);
        if (!m_full) begin m_left--; m_busy = (m_left > 0); end
      end
    end
    mrv = sched[k % 16];
    if (mrv) mrd = dqi;
    sched[k % 16] = 0;
    m_maskd = rdb && bm;
    k++;
    @(negedge clk);
  endtask

  task automatic cmd(bit w, logic [COL_W-1:0] c, logic [2:0] len);
    c_v = 1; c_w = w; c_col = c; c_len = len; wd = DATA_W'($urandom);
    step();
    c_v = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin wd = DATA_W'($urandom); step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) sched[i] = 0;
    @(negedge clk);
    repeat (3) begin
      #1;
      chk(dq_oe == 1'b0, "R11", "dq_oe in reset", 32'(dq_oe), 0);
      chk(dqm == 1'b0, "R11", "dqm in reset", 32'(dqm), 0);
      chk(rd_valid == 1'b0, "R11", "rd_valid in reset", 32'(rd_valid), 0);
      @(negedge clk);
    end
    rst_n = 1;

    focus = "R3"; cmd(1, 8'h05, 3'd3); idle(7);
    focus = "R10"; idle(1);
    focus = "R2"; cmd(1, 8'h33, 3'd1); idle(2);

    focus = "R5"; cl = 0;
    c_v = 1; c_w = 0; c_col = 8'h12; c_len = 3'd2; bm = 0; step();
    c_v = 0; bm = 1; step(); bm = 0; idle(6);
    cl = 1;
    c_v = 1; c_w = 0; c_col = 8'h1e; c_len = 3'd2; bm = 1; step();
    c_v = 0; bm = 0; idle(7);

    focus = "R7";
    cmd(1, 8'h00, 3'd3); idle(2);
    cmd(0, 8'h40, 3'd2); idle(1);
    cmd(0, 8'h50, 3'd1); cmd(0, 8'h52, 3'd1); cmd(0, 8'h60, 3'd1); idle(8);

    focus = "R8"; cmd(1, 8'hfe, 3'd7); idle(5);
    focus = "R9"; stp = 1; step(); stp = 0; idle(2);
    cmd(0, 8'h20, 3'd7); idle(2); stp = 1; step(); stp = 0; idle(6);
    cmd(1, 8'h44, 3'd2); stp = 1; idle(4); stp = 0; idle(2);
    focus = "";

    for (int r = 0; r < 6; r++) begin
      cl = r[0];
      for (int i = 0; i < 500; i++) begin
        c_v   = ($urandom % 5) == 0;
        c_w   = $urandom % 2;
        c_col = COL_W'($urandom);
        case ($urandom % 6)
          0: c_len = 3'd0; 1: c_len = 3'd1; 2: c_len = 3'd2;
          3: c_len = 3'd3; 4: c_len = 3'd7; default: c_len = 3'd5;
        endcase
        bm  = ($urandom % 4) == 0;
        stp = ($urandom % 8) == 0;
        wd  = DATA_W'($urandom);
        step();
      end
      c_v = 0; bm = 0; stp = 1; idle(12); stp = 0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule